// File: doc/BRIEF.md
# Three-Valued Flip-Flop Emulator

This block models one positive-edge flip-flop in which each logic signal has one of three levels: low, high or undefined. An undefined level is one that could resolve to either low or high. Each emulated signal travels as a 2-bit code. A fast system clock samples these codes as ordinary data. From one system cycle to the next, the block compares the previous clock level with the current one. It sorts each change as a clean rising edge, an ambiguous edge, or no edge. It then updates the stored level and drives the true and complement outputs.

A build-time parameter chooses the variant. One variant loads from a single data input. The other follows the J/K rules, with hold, set, reset and toggle. Asynchronous set and clear override all clock activity. An ambiguous clock edge corrupts the stored level only when the data has changed since the last sampled edge. When any input is undefined, the block gives the worst-case result. A defined level is kept only when every possible resolution of the undefined inputs agrees.

Top module: `triflop_top`

## Requirements
- R1: Level codes are 2'b00 low, 2'b01 high and 2'b10 undefined. Any input carrying 2'b11 is treated as undefined. The outputs never carry 2'b11.
- R2: After reset, `q` and `qBar` both read undefined. The remembered clock level and the remembered data are also undefined.
- R3: If set is high and clear is low, `q` becomes high on the next system cycle. If clear is high and set is low, `q` becomes low. If both are high, `q` becomes undefined. This happens whatever the clock does.
- R4: Suppose set or clear is undefined, and the other is low. The stored level is kept if it already equals the level the undefined input would force. Otherwise it becomes undefined. Clock edges have no effect during this time.
- R5: In data mode, a clean rising edge loads the data level into `q`. A clean rising edge is low in one system cycle followed by high in the next. `q` shows the new level one system cycle after the high sample.
- R6: In J/K mode, a clean edge acts on the stored level as follows. J=0,K=0 holds it. J=1,K=0 sets it high. J=0,K=1 sets it low. J=1,K=1 inverts it.
- R7: In J/K mode, an undefined J, K or stored level on a clean edge gives a defined result only when every resolution agrees. Otherwise the result is undefined.
- R8: An ambiguous edge is low to undefined, or undefined to high. If the data differs from the data remembered at the last clean or ambiguous edge, an ambiguous edge makes `q` undefined.
- R9: An ambiguous edge with data unchanged since the last clean or ambiguous edge keeps the stored level.
- R10: Other clock changes leave the stored level untouched. These are falling, high to undefined, undefined to low, and steady levels.
- R11: `qBar` is the three-valued inverse of `q`: low gives high, high gives low, and undefined gives undefined.
- R12: Every clean or ambiguous edge updates the remembered data, including an edge that meets an asynchronous override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the emulated signals |
| rst_n | input | 1 | Active-low synchronous reset |
| ckIn | input | 2 | Emulated flip-flop clock level |
| setIn | input | 2 | Emulated asynchronous set level |
| clrIn | input | 2 | Emulated asynchronous clear level |
| dIn | input | 2 | Data level (data mode) |
| jIn | input | 2 | J level (J/K mode) |
| kIn | input | 2 | K level (J/K mode) |
| q | output | 2 | Stored level |
| qBar | output | 2 | Three-valued complement of `q` |

## Verification
On every cycle, the assertions check four things. The stored code is always legal. The level holds when no edge and no override occur. An ambiguous edge with unchanged data preserves the state. A firm set or clear lands in the next cycle. The complement and the spacing between edges are also checked continuously. Some behaviours can only be shown by the bench's scenarios. These are the value loaded on a clean edge, the J/K toggle, and the resolution of undefined J/K inputs. They also include the soft hold under an undefined set or clear, and the refresh of the remembered data on an ambiguous edge.

// File: rtl/triflop_pkg.sv
package triflop_pkg;

  localparam int LVL_W  = 2;
  localparam int DATA_W = 2 * LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_LO = 2'b00;
  localparam lvl_t LVL_HI = 2'b01;
  localparam lvl_t LVL_UN = 2'b10;

  typedef struct packed {
    logic cleanEdge;
    logic fuzzyEdge;
    logic forceOn;
    logic forceSoft;
    lvl_t forceLvl;
  } strobe_t;

  function automatic lvl_t normLvl(input lvl_t a);
    return (a == 2'b11) ? LVL_UN : a;
  endfunction

  function automatic lvl_t invLvl(input lvl_t a);
    lvl_t n;
    n = normLvl(a);
    if (n == LVL_LO) return LVL_HI;
    if (n == LVL_HI) return LVL_LO;
    return LVL_UN;
  endfunction

  // true when bit value b is a possible resolution of level a
  function automatic logic canBe(input lvl_t a, input logic b);
    return (normLvl(a) == LVL_UN) || (a[0] == b);
  endfunction

  // enumerate every resolution of j, k and the stored level
  function automatic lvl_t jkResolve(input lvl_t j, input lvl_t k, input lvl_t s);
    logic seen0, seen1, r;
    seen0 = 1'b0;
    seen1 = 1'b0;
    for (int jb = 0; jb < 2; jb++) begin
      for (int kb = 0; kb < 2; kb++) begin
        for (int sb = 0; sb < 2; sb++) begin
          if (canBe(j, jb[0]) && canBe(k, kb[0]) && canBe(s, sb[0])) begin
            r = (jb[0] & ~sb[0]) | (~kb[0] & sb[0]);
            if (r) seen1 = 1'b1;
            else   seen0 = 1'b1;
          end
        end
      end
    end
    if (seen0 && seen1) return LVL_UN;
    return seen1 ? LVL_HI : LVL_LO;
  endfunction

endpackage

// File: rtl/triflop_ctrl.sv
module triflop_ctrl
  import triflop_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  lvl_t    ckIn,
  input  lvl_t    setIn,
  input  lvl_t    clrIn,
  output strobe_t strobes
);

  lvl_t prevCk, ckNow, setLvl, clrLvl;

  assign ckNow  = normLvl(ckIn);
  assign setLvl = normLvl(setIn);
  assign clrLvl = normLvl(clrIn);

  always_ff @(posedge clk) begin
    if (!rst_n) prevCk <= LVL_UN;
    else        prevCk <= ckNow;
  end

  always_comb begin
    strobes.cleanEdge = (prevCk == LVL_LO) && (ckNow == LVL_HI);
    strobes.fuzzyEdge = ((prevCk == LVL_LO) && (ckNow == LVL_UN)) ||
                        ((prevCk == LVL_UN) && (ckNow == LVL_HI));
    strobes.forceOn   = 1'b1;
    strobes.forceSoft = 1'b0;
    strobes.forceLvl  = LVL_UN;
    if (setLvl == LVL_LO && clrLvl == LVL_LO) begin
      strobes.forceOn = 1'b0;
    end else if (setLvl == LVL_HI && clrLvl == LVL_LO) begin
      strobes.forceLvl = LVL_HI;
    end else if (clrLvl == LVL_HI && setLvl == LVL_LO) begin
      strobes.forceLvl = LVL_LO;
    end else if (setLvl == LVL_UN && clrLvl == LVL_LO) begin
      strobes.forceSoft = 1'b1;
      strobes.forceLvl  = LVL_HI;
    end else if (clrLvl == LVL_UN && setLvl == LVL_LO) begin
      strobes.forceSoft = 1'b1;
      strobes.forceLvl  = LVL_LO;
    end
  end

  // a rising edge is never immediately followed by another edge
  assert_edge_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.cleanEdge |=> !(strobes.cleanEdge || strobes.fuzzyEdge));

endmodule

// File: rtl/triflop_dp.sv
module triflop_dp
  import triflop_pkg::*;
#(
  parameter bit JK_MODE = 1'b0
)(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strobes,
  input  lvl_t    dIn,
  input  lvl_t    jIn,
  input  lvl_t    kIn,
  output lvl_t    q
);

  lvl_t state, nextState, edgeLvl;
  logic [DATA_W-1:0] dataNow, lastData;

  assign dataNow = JK_MODE ? {normLvl(jIn), normLvl(kIn)} : {LVL_LO, normLvl(dIn)};
  assign edgeLvl = JK_MODE ? jkResolve(jIn, kIn, state) : normLvl(dIn);

  always_comb begin
    nextState = state;
    if (strobes.forceOn) begin
      if (!strobes.forceSoft)                 nextState = strobes.forceLvl;
      else if (state != strobes.forceLvl)     nextState = LVL_UN;
    end else if (strobes.cleanEdge) begin
      nextState = edgeLvl;
    end else if (strobes.fuzzyEdge) begin
      if (dataNow != lastData) nextState = LVL_UN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LVL_UN;
      lastData <= {LVL_UN, LVL_UN};
    end else begin
      state <= nextState;
      if (strobes.cleanEdge || strobes.fuzzyEdge) lastData <= dataNow;
    end
  end

  assign q = state;

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.forceOn || strobes.cleanEdge || strobes.fuzzyEdge) |=> $stable(state));

  assert_fuzzy_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.fuzzyEdge && !strobes.forceOn && dataNow == lastData) |=> $stable(state));

  assert_hard_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.forceOn && !strobes.forceSoft) |=> state == $past(strobes.forceLvl));

endmodule

// File: rtl/triflop_top.sv
module triflop_top
  import triflop_pkg::*;
#(
  parameter bit JK_MODE = 1'b0
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ckIn,
  input  logic [1:0] setIn,
  input  logic [1:0] clrIn,
  input  logic [1:0] dIn,
  input  logic [1:0] jIn,
  input  logic [1:0] kIn,
  output logic [1:0] q,
  output logic [1:0] qBar
);

  strobe_t strobes;

  triflop_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ckIn    (ckIn),
    .setIn   (setIn),
    .clrIn   (clrIn),
    .strobes (strobes)
  );

  triflop_dp #(.JK_MODE(JK_MODE)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .dIn     (dIn),
    .jIn     (jIn),
    .kIn     (kIn),
    .q       (q)
  );

  assign qBar = invLvl(q);

  assert_undef_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q == LVL_UN) |-> (qBar == LVL_UN));

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (normLvl(clrIn) == LVL_HI && normLvl(setIn) == LVL_LO) |=> q == LVL_LO);

endmodule

// File: tb/test_triflop_top.sv
`timescale 1ns/1ps
module test_triflop_top;

  localparam logic [1:0] L = 2'b00, H = 2'b01, U = 2'b10, W = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ckIn = L, setIn = L, clrIn = L, dIn = L, jIn = L, kIn = L;
  logic [1:0] qD, qbD, qJ, qbJ;
  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] expD;
    logic [1:0] expJ;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  triflop_top #(.JK_MODE(1'b0)) i_triflop_top (
    .clk(clk), .rst_n(rst_n), .ckIn(ckIn), .setIn(setIn), .clrIn(clrIn),
    .dIn(dIn), .jIn(jIn), .kIn(kIn), .q(qD), .qBar(qbD));

  triflop_top #(.JK_MODE(1'b1)) i_triflop_top_jk (
    .clk(clk), .rst_n(rst_n), .ckIn(ckIn), .setIn(setIn), .clrIn(clrIn),
    .dIn(dIn), .jIn(jIn), .kIn(kIn), .q(qJ), .qBar(qbJ));

  function automatic logic [1:0] expInv(input logic [1:0] a);
    return (a == L) ? H : (a == H) ? L : U;
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] ck, input logic [1:0] s, input logic [1:0] c,
                      input logic [1:0] d, input logic [1:0] j, input logic [1:0] k,
                      input logic [1:0] eD, input logic [1:0] eJ, input string tag);
    @(negedge clk);
    ckIn = ck; setIn = s; clrIn = c; dIn = d; jIn = j; kIn = k;
    sbq.push_back('{eD, eJ, tag});
  endtask

  // monitor: one expected item per cycle, compared after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        if (it.expD != W) begin
          chk(qD,  it.expD,         "data q",    it.tag);
          chk(qbD, expInv(it.expD), "data qBar R11", it.tag);
        end
        if (it.expJ != W) begin
          chk(qJ,  it.expJ,         "jk q",      it.tag);
          chk(qbJ, expInv(it.expJ), "jk qBar R11", it.tag);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //    ck set clr d  j  k   expD expJ
    step(L, L, L, L, L, L,  U, U, "R2 reset state");
    step(H, L, L, H, H, L,  H, H, "R5 R6 clean edge load/set");
    step(L, L, L, L, L, H,  H, H, "R10 falling edge");
    step(H, L, L, L, L, H,  L, L, "R5 R6 clean edge load/reset");
    step(L, L, L, L, H, H,  L, L, "R10 falling edge");
    step(H, L, L, L, H, H,  L, H, "R6 toggle up");
    step(L, L, L, L, H, H,  L, H, "R10 falling edge");
    step(H, L, L, L, H, H,  L, L, "R6 toggle down");
    step(L, L, L, H, L, L,  L, L, "R10 falling edge");
    step(H, L, L, H, L, L,  H, L, "R5 R6 load and hold");
    step(L, L, L, H, L, L,  H, L, "R10 falling edge");
    step(U, L, L, H, L, L,  H, L, "R9 low-to-undef same data");
    step(H, L, L, H, L, L,  H, L, "R9 undef-to-high same data");
    step(L, L, L, L, H, L,  H, L, "R10 falling edge");
    step(U, L, L, L, H, L,  U, U, "R8 ambiguous edge new data");
    step(L, H, L, L, H, L,  H, H, "R3 set high");
    step(U, L, L, L, H, L,  H, H, "R12 data refreshed on ambiguous edge");
    step(L, L, H, H, H, L,  L, L, "R3 clear high");
    step(L, H, H, H, H, L,  U, U, "R3 set and clear high");
    step(H, L, L, H, H, L,  H, H, "R5 R6 clean edge after override");
    step(L, U, L, H, H, L,  H, H, "R4 undefined set matches");
    step(L, L, U, H, H, L,  U, U, "R4 undefined clear differs");
    step(L, L, H, H, H, L,  L, L, "R3 clear high");
    step(H, L, U, H, H, L,  L, L, "R4 edge ignored under undefined clear");
    step(L, L, L, L, L, L,  L, L, "R10 falling edge");
    step(H, L, L, U, H, U,  U, H, "R1 R7 undefined d, J=1 K=U from low");
    step(L, L, L, W, U, L,  U, H, "R10 falling edge");
    step(H, L, L, W, U, L,  U, H, "R1 R7 code 11 on d, J=U K=0 from high");
    step(L, L, L, H, U, H,  U, H, "R10 falling edge");
    step(H, L, L, H, U, H,  H, L, "R7 J=U K=1 from high");
    step(L, L, L, L, U, U,  H, L, "R10 falling edge");
    step(H, L, L, L, U, U,  L, U, "R7 J=U K=U from low");
    step(L, L, L, H, L, L,  L, U, "R10 falling edge");
    step(W, L, L, H, L, L,  U, U, "R1 R8 clock code 11 ambiguous");
    step(L, H, L, H, H, L,  H, H, "R3 set high");
    step(H, L, L, H, H, L,  H, H, "R5 R6 clean edge");
    step(U, L, L, L, L, H,  H, H, "R10 high-to-undef no effect");
    step(L, L, L, L, L, H,  H, H, "R10 undef-to-low no effect");
    step(H, L, H, H, H, L,  L, L, "R3 clear beats clean edge");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule